// File: doc/BRIEF.md
# Smart Card Wait Time Supervisor

This block watches the character timing of a smart card link that follows ISO 7816 and flags the card when it stays silent too long. It counts elementary time units (ETUs) from a tick strobe supplied by the bit engine. It runs two timers. The long timer measures either the block wait (protocol T=1) or the work wait (protocol T=0). The short timer measures the gap between received characters. That gap is the initial wait while the answer-to-reset is being received, and the character wait under T=1 afterwards.

Firmware programs a 28-bit long limit and a 16-bit short limit through byte-wide writes. It selects the protocol and the answer-to-reset phase with level inputs. The character engine reports transmitted and received character edges as single-cycle pulses. Each timeout sets a sticky flag that firmware clears by writing 1 to it. An interrupt line combines the flags that are enabled. To grant a wait time extension, firmware writes a larger long limit, and the new value takes effect at the next arm.

Top module: `sc_wait_supervisor`

## Requirements
- R1: After reset both limits, both flags and both interrupt enables are zero and `irq` is low. A timer whose limit is still zero never times out.
- R2: The long limit is written at addresses 0 to 3, least significant byte at address 0. At address 3 only data bits 3:0 are kept (limit bits 27:24), and data bits 7:4 there are ignored.
- R3: The short limit is written at address 4 (bits 7:0) and address 5 (bits 15:8).
- R4: With `proto_t1` high, a `tx_last_char` pulse arms the long timer. `long_flag` rises on the edge that samples the limit-th `etu_tick` after the arm, unless an `rx_char_start` pulse stops the timer before that.
- R5: With `proto_t1` low, every `tx_char_start` or `rx_char_start` pulse restarts the long timer from zero. `long_flag` rises on the limit-th tick after the latest such pulse, and `tx_last_char` alone does not arm it.
- R6: The long limit is captured when the timer is armed. A rewrite of the limit while the timer runs takes effect only at the next arm.
- R7: While `atr_phase` or `proto_t1` is high, each `rx_char_start` restarts the short timer, and `short_flag` rises on the limit-th tick with no further received character. With both inputs low the short timer is idle.
- R8: A high `short_disable` stops the short timer until the next received character. A zero short limit keeps the short timer from arming.
- R9: The flags are sticky. A write to address 6 clears `long_flag` where data bit 0 is 1 and `short_flag` where data bit 1 is 1. A timeout in the same cycle as the clear leaves the flag set.
- R10: Address 7 holds the interrupt enables: bit 0 for the long flag, bit 1 for the short flag. `irq` is high exactly when an enabled flag is set.
- R11: A timer stops when it times out. After its flag is cleared it does not raise the flag again until it is armed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| etu_tick | input | 1 | One-cycle strobe per elapsed ETU |
| proto_t1 | input | 1 | 1 selects protocol T=1, 0 selects T=0 |
| atr_phase | input | 1 | High while the answer-to-reset is being received |
| tx_char_start | input | 1 | Pulse at the leading edge of a transmitted character |
| rx_char_start | input | 1 | Pulse at the leading edge of a received character |
| tx_last_char | input | 1 | Pulse at the leading edge of the last transmitted character of a block |
| short_disable | input | 1 | Stops the short timer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (width derived from the limit widths) |
| reg_wdata | input | 8 | Register write data |
| long_flag | output | 1 | Sticky long timer timeout |
| short_flag | output | 1 | Sticky short timer timeout |
| irq | output | 1 | Interrupt, OR of the enabled flags |

## Verification
The bench builds the block with its default widths of 28 and 16 bits, so the nibble-wide top byte of the long limit and the 3-bit address space are the real ones. Limits of a few ticks keep the runs short. A long limit of 258 (0x0102) checks that the byte order of the timer is right and that it stops exactly on the limit-th tick. Writing 0xF0 to the top byte shows that the ignored upper nibble does not turn a short limit into an unreachable one.

// File: rtl/sc_wait_pkg.sv
package sc_wait_pkg;
   // flag bit positions shared by clear and enable registers
   localparam int FLG_LONG  = 0;
   localparam int FLG_SHORT = 1;
   localparam int NUM_FLG   = 2;

   function automatic int bytes_for(input int w);
      return (w + 7) / 8;
   endfunction
endpackage

// File: rtl/sc_wait_limreg.sv
module sc_wait_limreg #(
   parameter int W    = 28,
   parameter int AW   = 3,
   parameter int BASE = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [7:0]    wdata,
   output wire  [W-1:0]  limit
);
   localparam int NB = sc_wait_pkg::bytes_for(W);

   for (genvar i = 0; i < NB; i++) begin : g_byte
      localparam int BW = ((W - 8*i) >= 8) ? 8 : (W - 8*i);
      logic [BW-1:0] byte_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            byte_q <= '0;
         else if (wr_en && (addr == AW'(BASE + i)))
            byte_q <= wdata[BW-1:0];
      end
      assign limit[8*i +: BW] = byte_q;
   end
endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer #(
   parameter int W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         arm,
   input  logic         stop,
   input  logic         halt,
   input  logic [W-1:0] limit,
   output logic         hit,
   output logic         running
);
   logic [W-1:0] cnt_q;
   logic [W-1:0] lim_q;
   logic [W-1:0] cnt_nx;

   assign cnt_nx  = cnt_q + W'(1);
   assign hit     = running && tick && !arm && !stop && !halt && (cnt_nx == lim_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         lim_q   <= '0;
         running <= 1'b0;
      end else if (halt) begin
         running <= 1'b0;
      end else if (arm) begin
         cnt_q   <= '0;
         lim_q   <= limit;
         running <= (limit != '0);
      end else if (stop) begin
         running <= 1'b0;
      end else if (running && tick) begin
         cnt_q <= cnt_nx;
         if (cnt_nx == lim_q)
            running <= 1'b0;
      end
   end
endmodule

// File: rtl/sc_wait_supervisor.sv
module sc_wait_supervisor #(
   parameter  int LONG_W     = 28,
   parameter  int SHORT_W    = 16,
   localparam int LONG_NB    = sc_wait_pkg::bytes_for(LONG_W),
   localparam int SHORT_NB   = sc_wait_pkg::bytes_for(SHORT_W),
   localparam int SHORT_BASE = LONG_NB,
   localparam int CLR_ADDR   = LONG_NB + SHORT_NB,
   localparam int EN_ADDR    = CLR_ADDR + 1,
   localparam int ADDR_W     = $clog2(EN_ADDR + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              etu_tick,
   input  logic              proto_t1,
   input  logic              atr_phase,
   input  logic              tx_char_start,
   input  logic              rx_char_start,
   input  logic              tx_last_char,
   input  logic              short_disable,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic              long_flag,
   output logic              short_flag,
   output logic              irq
);
   import sc_wait_pkg::*;

   if (LONG_W < 2 || LONG_W > 32) begin : g_bad_long
      $error("LONG_W must lie in 2..32");
   end
   if (SHORT_W < 2 || SHORT_W > 32) begin : g_bad_short
      $error("SHORT_W must lie in 2..32");
   end

   wire  [LONG_W-1:0]  long_lim;
   wire  [SHORT_W-1:0] short_lim;
   logic [NUM_FLG-1:0] flags_q;
   logic [NUM_FLG-1:0] en_q;
   logic [NUM_FLG-1:0] clr_mask;
   logic [NUM_FLG-1:0] hits;
   logic long_hit, short_hit, long_run, short_run;
   logic long_arm, long_stop, short_arm, short_halt, short_active;

   sc_wait_limreg #(.W(LONG_W), .AW(ADDR_W), .BASE(0)) u_long_lim (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .limit(long_lim));

   sc_wait_limreg #(.W(SHORT_W), .AW(ADDR_W), .BASE(SHORT_BASE)) u_short_lim (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .limit(short_lim));

   // long timer: block wait under T=1, work wait under T=0
   assign long_arm  = proto_t1 ? tx_last_char : (tx_char_start | rx_char_start);
   assign long_stop = proto_t1 & rx_char_start;

   sc_wait_timer #(.W(LONG_W)) u_long (
      .clk(clk), .rst_n(rst_n), .tick(etu_tick), .arm(long_arm),
      .stop(long_stop), .halt(1'b0), .limit(long_lim),
      .hit(long_hit), .running(long_run));

   // short timer: initial wait during ATR, character wait under T=1
   assign short_active = atr_phase | proto_t1;
   assign short_arm    = short_active & rx_char_start;
   assign short_halt   = short_disable | ~short_active;

   sc_wait_timer #(.W(SHORT_W)) u_short (
      .clk(clk), .rst_n(rst_n), .tick(etu_tick), .arm(short_arm),
      .stop(1'b0), .halt(short_halt), .limit(short_lim),
      .hit(short_hit), .running(short_run));

   assign hits[FLG_LONG]  = long_hit;
   assign hits[FLG_SHORT] = short_hit;
   assign clr_mask = (reg_wr && reg_addr == ADDR_W'(CLR_ADDR)) ?
                     reg_wdata[NUM_FLG-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         en_q    <= '0;
      end else begin
         flags_q <= (flags_q & ~clr_mask) | hits;
         if (reg_wr && reg_addr == ADDR_W'(EN_ADDR))
            en_q <= reg_wdata[NUM_FLG-1:0];
      end
   end

   assign long_flag  = flags_q[FLG_LONG];
   assign short_flag = flags_q[FLG_SHORT];
   assign irq        = |(flags_q & en_q);
endmodule

// File: rtl/sc_wait_chk.sv
module sc_wait_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       proto_t1,
   input logic       atr_phase,
   input logic       short_disable,
   input logic [1:0] clr_mask,
   input logic       long_run,
   input logic       short_run,
   input logic       long_flag,
   input logic       short_flag,
   input logic       irq
);
   // R9
   long_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (long_flag && !clr_mask[0]) |=> long_flag);
   // R9
   short_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (short_flag && !clr_mask[1]) |=> short_flag);
   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (long_flag || short_flag));
   // R11
   long_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(long_flag) |-> !long_run);
   // R11
   short_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(short_flag) |-> !short_run);
   // R4
   long_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(long_flag) |-> $past(long_run));
   // R7
   short_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proto_t1 && !atr_phase) |=> !short_run);
   // R8
   short_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_disable |=> !short_run);
endmodule

bind sc_wait_supervisor sc_wait_chk u_chk (
   .clk(clk), .rst_n(rst_n), .proto_t1(proto_t1), .atr_phase(atr_phase),
   .short_disable(short_disable), .clr_mask(clr_mask),
   .long_run(long_run), .short_run(short_run),
   .long_flag(long_flag), .short_flag(short_flag), .irq(irq));

// File: tb/sc_wait_supervisor_tb.sv
module sc_wait_supervisor_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic etu_tick = 0, proto_t1 = 1, atr_phase = 0;
   logic tx_char_start = 0, rx_char_start = 0, tx_last_char = 0, short_disable = 0;
   logic reg_wr = 0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic long_flag, short_flag, irq;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sc_wait_supervisor dut_i (
      .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .proto_t1(proto_t1),
      .atr_phase(atr_phase), .tx_char_start(tx_char_start),
      .rx_char_start(rx_char_start), .tx_last_char(tx_last_char),
      .short_disable(short_disable), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .long_flag(long_flag), .short_flag(short_flag),
      .irq(irq));

   task automatic chk(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); etu_tick = 1;
         @(negedge clk); etu_tick = 0;
      end
   endtask

   task automatic ev(input logic txs, input logic rxs, input logic last);
      @(negedge clk);
      tx_char_start = txs; rx_char_start = rxs; tx_last_char = last;
      @(negedge clk);
      tx_char_start = 0; rx_char_start = 0; tx_last_char = 0;
   endtask

   task automatic set_long(input logic [27:0] v);
      wr(3'd0, v[7:0]); wr(3'd1, v[15:8]); wr(3'd2, v[23:16]); wr(3'd3, {4'h0, v[27:24]});
   endtask

   task automatic set_short(input logic [15:0] v);
      wr(3'd4, v[7:0]); wr(3'd5, v[15:8]);
   endtask

   task automatic t_reset;
      chk("R1 long_flag after reset", long_flag, 0);
      chk("R1 short_flag after reset", short_flag, 0);
      chk("R1 irq after reset", irq, 0);
      proto_t1 = 1;
      ev(1, 0, 1);
      ev(0, 1, 0);
      ticks(4);
      chk("R1 zero long limit no timeout", long_flag, 0);
      chk("R1 zero short limit no timeout", short_flag, 0);
   endtask

   task automatic t_bytes;
      wr(3'd7, 8'h03);
      wr(3'd0, 8'h05); wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd3, 8'hF0);
      ev(1, 0, 1);
      ticks(4);
      chk("R2 long before 5th tick", long_flag, 0);
      ticks(1);
      chk("R2 top nibble ignored, flag at 5", long_flag, 1);
      chk("R10 irq with long enabled", irq, 1);
      wr(3'd6, 8'h03);
      set_long(28'h0000102);
      ev(1, 0, 1);
      ticks(257);
      chk("R2 byte order, before tick 258", long_flag, 0);
      ticks(1);
      chk("R2 byte order, flag at tick 258", long_flag, 1);
      wr(3'd6, 8'h03);
   endtask

   task automatic t_short_order;
      proto_t1 = 1; atr_phase = 0;
      set_short(16'h0102);
      ev(0, 1, 0);
      ticks(257);
      chk("R3 short before tick 258", short_flag, 0);
      ticks(1);
      chk("R3 short flag at tick 258", short_flag, 1);
      wr(3'd6, 8'h03);
   endtask

   task automatic t_t1_stop;
      proto_t1 = 1;
      set_long(28'd6);
      ev(1, 0, 1);
      ticks(3);
      ev(0, 1, 0);
      ticks(10);
      chk("R4 received char stops block wait", long_flag, 0);
      ev(1, 0, 1);
      ticks(6);
      chk("R4 block wait expires at limit", long_flag, 1);
      wr(3'd6, 8'h03);
   endtask

   task automatic t_t0;
      proto_t1 = 0; atr_phase = 0;
      set_long(28'd4);
      ev(1, 0, 0);
      ticks(3);
      ev(0, 1, 0);
      ticks(3);
      chk("R5 rx char restarts work wait", long_flag, 0);
      ticks(1);
      chk("R5 work wait expires after last char", long_flag, 1);
      wr(3'd6, 8'h03);
      ev(0, 0, 1);
      ticks(6);
      chk("R5 last-char pulse alone does not arm in T0", long_flag, 0);
      proto_t1 = 1;
   endtask

   task automatic t_wtx;
      proto_t1 = 1;
      set_long(28'd4);
      ev(1, 0, 1);
      ticks(1);
      wr(3'd0, 8'd10);
      ticks(3);
      chk("R6 running timer keeps captured limit", long_flag, 1);
      wr(3'd6, 8'h03);
      ev(1, 0, 1);
      ticks(9);
      chk("R6 new limit after re-arm, tick 9", long_flag, 0);
      ticks(1);
      chk("R6 new limit after re-arm, tick 10", long_flag, 1);
      wr(3'd6, 8'h03);
   endtask

   task automatic t_short;
      proto_t1 = 0; atr_phase = 1;
      set_long(28'd0);
      set_short(16'd3);
      ev(0, 1, 0);
      ticks(2);
      ev(0, 1, 0);
      ticks(2);
      chk("R7 ATR rx char restarts short timer", short_flag, 0);
      ticks(1);
      chk("R7 initial wait expires", short_flag, 1);
      wr(3'd6, 8'h03);
      atr_phase = 0;
      ev(0, 1, 0);
      ticks(5);
      chk("R7 short idle in T0 outside ATR", short_flag, 0);
      proto_t1 = 1;
      ev(0, 1, 0);
      ticks(3);
      chk("R7 character wait under T1", short_flag, 1);
      wr(3'd6, 8'h03);
   endtask

   task automatic t_disable;
      proto_t1 = 1; atr_phase = 0;
      set_short(16'd3);
      ev(0, 1, 0);
      ticks(1);
      @(negedge clk); short_disable = 1;
      @(negedge clk); short_disable = 0;
      ticks(5);
      chk("R8 disable stops short timer", short_flag, 0);
      ev(0, 1, 0);
      ticks(3);
      chk("R8 rx char re-arms after disable", short_flag, 1);
      wr(3'd6, 8'h03);
      set_short(16'd0);
      ev(0, 1, 0);
      ticks(5);
      chk("R8 zero short limit never arms", short_flag, 0);
   endtask

   task automatic t_sticky;
      proto_t1 = 1;
      set_long(28'd2);
      set_short(16'd2);
      ev(1, 0, 1);
      ev(0, 0, 1);
      ticks(2);
      chk("R9 long flag set", long_flag, 1);
      ticks(5);
      chk("R9 long flag stays without clear", long_flag, 1);
      wr(3'd6, 8'h02);
      chk("R9 clearing bit 1 keeps long flag", long_flag, 1);
      wr(3'd6, 8'h01);
      chk("R9 clearing bit 0 clears long flag", long_flag, 0);
      ev(1, 0, 1);
      ticks(1);
      @(negedge clk);
      etu_tick = 1; reg_wr = 1; reg_addr = 3'd6; reg_wdata = 8'h01;
      @(negedge clk);
      etu_tick = 0; reg_wr = 0;
      chk("R9 timeout wins over same-cycle clear", long_flag, 1);
      wr(3'd6, 8'h03);
   endtask

   task automatic t_irq;
      proto_t1 = 1;
      wr(3'd7, 8'h01);
      set_short(16'd2);
      set_long(28'd10);
      ev(0, 1, 0);
      ticks(2);
      chk("R10 short flag set", short_flag, 1);
      chk("R10 short flag masked off irq", irq, 0);
      ev(1, 0, 1);
      ticks(10);
      chk("R10 enabled long flag drives irq", irq, 1);
      wr(3'd7, 8'h00);
      chk("R10 irq low with both disabled", irq, 0);
      chk("R10 flag unaffected by mask", long_flag, 1);
      wr(3'd7, 8'h03);
      wr(3'd6, 8'h03);
   endtask

   task automatic t_stop;
      proto_t1 = 1;
      set_short(16'd0);
      set_long(28'd3);
      ev(1, 0, 1);
      ticks(3);
      chk("R11 long timeout", long_flag, 1);
      wr(3'd6, 8'h01);
      ticks(12);
      chk("R11 no second timeout without re-arm", long_flag, 0);
      chk("R11 irq stays low", irq, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_bytes();
      t_short_order();
      t_t1_stop();
      t_t0();
      t_wtx();
      t_short();
      t_disable();
      t_sticky();
      t_irq();
      t_stop();
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule